// File: doc/BRIEF.md
# Descriptor Ring DMA Sequencer

This block walks two descriptor rings in host memory, one for receive and one for transmit, over a single-beat bus-master port. Each descriptor takes 8 bytes. The first word holds a 12-bit byte count. The second word holds a 24-bit buffer address in its low three bytes and a status byte in its top byte. Bit 7 of the status byte means the hardware owns the descriptor.

A write to the prompt input wakes any ring that is idle. The ring then fetches the descriptor at its current index. If the hardware owns that descriptor, the ring holds the count, the buffer address and the status flags and presents them to the frame engine. When the frame engine reports completion, the ring writes the second word back with the ownership bit cleared and the final flags filled in. It then advances its index modulo the ring size and fetches the next descriptor without waiting for another prompt.

Both rings share one 1 KB-aligned area. The receive ring sits at offset 0 and the transmit ring at offset 512. Address bits [31:24] of every bus cycle come from an 8-bit page input.

Each ring runs one state machine with these states:
- `RS_IDLE`: goes to `RS_FETCH_CNT` on a prompt.
- `RS_FETCH_CNT`: goes to `RS_FETCH_ADDR` when the bus acknowledges.
- `RS_FETCH_ADDR`: when the bus acknowledges, goes to `RS_HELD` if the ownership bit is set, and back to `RS_IDLE` if it is clear.
- `RS_HELD`: goes to `RS_CLOSE` when the frame engine reports done.
- `RS_CLOSE`: when the bus acknowledges, advances the index and goes to `RS_FETCH_CNT`.

Dropping the master enable sends a ring from any state to `RS_IDLE` and clears its index.

Top module: `ring_dma_seq`

## Requirements
- R1: After reset, the ring-pointer readback is 0, the size register reads 0, no descriptor is presented and no bus request is raised.
- R2: A size write stores bits [15:8], and bits [7:0] read back as 0. Bits [11:8] hold the receive size code and bits [15:12] the transmit size code. The codes 0000, 0001, 0011, 0111 and 1111 select 4, 8, 16, 32 and 64 entries.
- R3: A prompt starts a fetch on an idle ring. A ring that holds an owned descriptor ignores the prompt: its outputs, its index and the bus do not change.
- R4: A fetch reads the word at offset 0 of the descriptor and takes the count from bits [11:0]. It then reads the word at offset 4 and takes the buffer address from bits [23:0], the flags from bits [30:24] and the ownership bit from bit 31. The ring presents the buffer address as {page, address[23:0]}.
- R5: A fetched descriptor with bit 31 clear returns the ring to idle. The index does not advance and no descriptor is presented.
- R6: On frame done, the ring writes the offset-4 word back as {0, done flags[6:0], buffer address[23:0]}, which clears ownership.
- R7: After a close, the index advances modulo the ring size and the next descriptor is fetched with no further prompt.
- R8: Every bus address is {page[7:0], base[13:0], ring (0 for receive, 1 for transmit), index[5:0], word, 2'b00}.
- R9: The pointer readback carries the receive index in bits [5:0] and the transmit index in bits [13:8]. All other bits are 0.
- R10: When both rings request the bus, the receive ring is granted first. A granted request keeps its address stable until it is acknowledged.
- R11: While the master enable is low, both rings are idle and both indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master enable; low stops both rings and clears their indices |
| prompt | input | 1 | One-cycle pulse for a prompt-register write |
| page | input | 8 | Address bits [31:24] of all bus cycles |
| ring_base | input | 14 | Address bits [23:10] of the ring area |
| size_wr | input | 1 | Size register write strobe |
| size_wdata | input | 16 | Size register write data |
| size_q | output | 16 | Size register readback |
| ring_ptr | output | 16 | Combined ring index readback |
| bm_req | output | 1 | Bus request, held until acknowledged |
| bm_we | output | 1 | Bus write (1) or read (0) |
| bm_addr | output | 32 | Bus byte address |
| bm_wdata | output | 32 | Bus write data |
| bm_ack | input | 1 | Bus acknowledge; read data valid in this cycle |
| bm_rdata | input | 32 | Bus read data |
| rx_valid | output | 1 | Receive descriptor held |
| rx_count | output | 12 | Receive descriptor count |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_flags | output | 7 | Receive descriptor flags |
| rx_done | input | 1 | Receive frame finished |
| rx_done_flags | input | 7 | Receive completion flags |
| tx_valid | output | 1 | Transmit descriptor held |
| tx_count | output | 12 | Transmit descriptor count |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_flags | output | 7 | Transmit descriptor flags |
| tx_done | input | 1 | Transmit frame finished |
| tx_done_flags | input | 7 | Transmit completion flags |

## Verification
A ring's request appears one cycle after the prompt edge, and each bus access ends one cycle after it is acknowledged. A held descriptor is visible on the edge after the acknowledge of the word at offset 4. The index advances on the edge that acknowledges the close write. A master-enable drop takes effect at the next edge. The bench drives inputs and samples outputs on the falling edge, so every result is read one full cycle after the edge that produces it. Long sequences are checked only after the rings have gone idle again.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 12;
    localparam int BUF_W  = 24;
    localparam int FLAG_W = 7;
    localparam int PAGE_W = 8;
    localparam int BASE_W = 14;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_FETCH_CNT,
        RS_FETCH_ADDR,
        RS_HELD,
        RS_CLOSE
    } ring_state_e;
endpackage

// File: rtl/ring_bus_arb.sv
module ring_bus_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_req,
    input  logic tx_req,
    input  logic bus_ack,
    output logic bus_req,
    output logic sel_tx,
    output logic rx_ack,
    output logic tx_ack
);
    logic locked;
    logic lock_tx;

    always_comb begin
        sel_tx  = locked ? lock_tx : (!rx_req && tx_req);
        bus_req = sel_tx ? tx_req : rx_req;
        rx_ack  = bus_ack && !sel_tx;
        tx_ack  = bus_ack && sel_tx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            lock_tx <= 1'b0;
        end else if (bus_ack || !bus_req) begin
            locked  <= 1'b0;
        end else begin
            locked  <= 1'b1;
            lock_tx <= sel_tx;
        end
    end

    // R10: an open transaction keeps its owner until acknowledged
    a_r10_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && rx_req && tx_req) |=> (sel_tx == $past(sel_tx)));
endmodule

// File: rtl/ring_ctl.sv
module ring_ctl
    import ring_dma_pkg::*;
#(
    parameter int IX_W  = IDX_W,
    parameter int CN_W  = CNT_W,
    parameter int BF_W  = BUF_W,
    parameter int FL_W  = FLAG_W,
    parameter int DW    = WORD_W,
    localparam int CODE_W = IX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              prompt,
    input  logic [CODE_W-1:0] size_code,
    input  logic              ack,
    input  logic [DW-1:0]     rdata,
    output logic              req,
    output logic              we,
    output logic              word_sel,
    output logic [IX_W-1:0]   idx,
    output logic [DW-1:0]     wdata,
    output logic              desc_valid,
    output logic [CN_W-1:0]   desc_count,
    output logic [BF_W-1:0]   desc_buf,
    output logic [FL_W-1:0]   desc_flags,
    input  logic              done,
    input  logic [FL_W-1:0]   done_flags
);
    ring_state_e     state;
    logic [IX_W-1:0] ptr;
    logic [IX_W-1:0] mask;
    logic [FL_W-1:0] close_flags;

    assign mask = {size_code, 2'b11};
    assign idx  = ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= RS_IDLE;
            ptr         <= '0;
            desc_count  <= '0;
            desc_buf    <= '0;
            desc_flags  <= '0;
            close_flags <= '0;
        end else if (!en) begin
            state <= RS_IDLE;
            ptr   <= '0;
        end else begin
            unique case (state)
                RS_IDLE:       if (prompt) state <= RS_FETCH_CNT;
                RS_FETCH_CNT:  if (ack) begin
                    desc_count <= rdata[CN_W-1:0];
                    state      <= RS_FETCH_ADDR;
                end
                RS_FETCH_ADDR: if (ack) begin
                    desc_buf   <= rdata[BF_W-1:0];
                    desc_flags <= rdata[DW-2 -: FL_W];
                    state      <= rdata[DW-1] ? RS_HELD : RS_IDLE;
                end
                RS_HELD:       if (done) begin
                    close_flags <= done_flags;
                    state       <= RS_CLOSE;
                end
                RS_CLOSE:      if (ack) begin
                    ptr   <= (ptr + 1'b1) & mask;
                    state <= RS_FETCH_CNT;
                end
                default:       state <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        req        = 1'b0;
        we         = 1'b0;
        word_sel   = 1'b1;
        desc_valid = 1'b0;
        wdata      = {1'b0, close_flags, desc_buf};
        unique case (state)
            RS_IDLE:       ;
            RS_FETCH_CNT:  begin req = 1'b1; word_sel = 1'b0; end
            RS_FETCH_ADDR: req = 1'b1;
            RS_HELD:       desc_valid = 1'b1;
            RS_CLOSE:      begin req = 1'b1; we = 1'b1; end
            default:       ;
        endcase
    end

    // R11: disable forces idle and index zero
    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == RS_IDLE && ptr == '0));
    // R5: unowned descriptor returns to idle without advancing
    a_r5_unowned_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == RS_FETCH_ADDR && ack && !rdata[DW-1]) |=> (state == RS_IDLE && ptr == $past(ptr)));
    // R7: close advances modulo ring size
    a_r7_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == RS_CLOSE && ack) |=> (ptr == (($past(ptr) + 1'b1) & $past(mask))));
    // R3: a held descriptor stays held regardless of prompt
    a_r3_held_ignores_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == RS_HELD && !done) |=> (state == RS_HELD));
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
    import ring_dma_pkg::*;
#(
    parameter int PG_W = PAGE_W,
    parameter int BS_W = BASE_W,
    parameter int IX_W = IDX_W,
    localparam int AW    = PG_W + BS_W + IX_W + 4,
    localparam int PAD_W = 8 - IX_W,
    localparam int CODE_W = IX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              prompt,
    input  logic [PG_W-1:0]   page,
    input  logic [BS_W-1:0]   ring_base,
    input  logic              size_wr,
    input  logic [15:0]       size_wdata,
    output logic [15:0]       size_q,
    output logic [15:0]       ring_ptr,
    output logic              bm_req,
    output logic              bm_we,
    output logic [AW-1:0]     bm_addr,
    output logic [WORD_W-1:0] bm_wdata,
    input  logic              bm_ack,
    input  logic [WORD_W-1:0] bm_rdata,
    output logic              rx_valid,
    output logic [CNT_W-1:0]  rx_count,
    output logic [AW-1:0]     rx_buf_addr,
    output logic [FLAG_W-1:0] rx_flags,
    input  logic              rx_done,
    input  logic [FLAG_W-1:0] rx_done_flags,
    output logic              tx_valid,
    output logic [CNT_W-1:0]  tx_count,
    output logic [AW-1:0]     tx_buf_addr,
    output logic [FLAG_W-1:0] tx_flags,
    input  logic              tx_done,
    input  logic [FLAG_W-1:0] tx_done_flags
);
    logic [7:0] size_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       size_reg <= '0;
        else if (size_wr) size_reg <= size_wdata[15:8];
    end
    assign size_q = {size_reg, 8'h00};

    logic              r_req   [2];
    logic              r_we    [2];
    logic              r_word  [2];
    logic              r_ack   [2];
    logic [IX_W-1:0]   r_idx   [2];
    logic [WORD_W-1:0] r_wdata [2];
    logic              r_valid [2];
    logic [CNT_W-1:0]  r_count [2];
    logic [BUF_W-1:0]  r_buf   [2];
    logic [FLAG_W-1:0] r_flags [2];
    logic              r_done  [2];
    logic [FLAG_W-1:0] r_dflags[2];

    assign r_done[0]   = rx_done;
    assign r_done[1]   = tx_done;
    assign r_dflags[0] = rx_done_flags;
    assign r_dflags[1] = tx_done_flags;

    for (genvar g = 0; g < 2; g++) begin : g_ring
        ring_ctl #(.IX_W(IX_W)) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (master_en),
            .prompt     (prompt),
            .size_code  (size_reg[4*g +: CODE_W]),
            .ack        (r_ack[g]),
            .rdata      (bm_rdata),
            .req        (r_req[g]),
            .we         (r_we[g]),
            .word_sel   (r_word[g]),
            .idx        (r_idx[g]),
            .wdata      (r_wdata[g]),
            .desc_valid (r_valid[g]),
            .desc_count (r_count[g]),
            .desc_buf   (r_buf[g]),
            .desc_flags (r_flags[g]),
            .done       (r_done[g]),
            .done_flags (r_dflags[g])
        );
    end

    logic sel_tx;

    ring_bus_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_req  (r_req[0]),
        .tx_req  (r_req[1]),
        .bus_ack (bm_ack),
        .bus_req (bm_req),
        .sel_tx  (sel_tx),
        .rx_ack  (r_ack[0]),
        .tx_ack  (r_ack[1])
    );

    always_comb begin
        bm_addr  = {page, ring_base, sel_tx, r_idx[sel_tx], r_word[sel_tx], 2'b00};
        bm_we    = r_we[sel_tx];
        bm_wdata = r_wdata[sel_tx];
    end

    assign ring_ptr    = {{PAD_W{1'b0}}, r_idx[1], {PAD_W{1'b0}}, r_idx[0]};
    assign rx_valid    = r_valid[0];
    assign rx_count    = r_count[0];
    assign rx_buf_addr = {page, r_buf[0]};
    assign rx_flags    = r_flags[0];
    assign tx_valid    = r_valid[1];
    assign tx_count    = r_count[1];
    assign tx_buf_addr = {page, r_buf[1]};
    assign tx_flags    = r_flags[1];

    // R10: pending bus cycle holds its address until acknowledged
    a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && !bm_ack && master_en) |=> (bm_req && $stable(bm_addr) && $stable(bm_we)));
    // R9: the index readback never shows a set padding bit
    a_r9_ptr_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_ptr[15:14] == 2'b00) && (ring_ptr[7:6] == 2'b00));
endmodule

// File: tb/test_ring_dma_seq.sv
module test_ring_dma_seq;
    localparam logic [7:0]  PG = 8'h5C;
    localparam logic [13:0] BS = 14'h02A7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0, prompt = 1'b0, size_wr = 1'b0;
    logic [15:0] size_wdata = '0;
    logic [15:0] size_q, ring_ptr;
    logic bm_req, bm_we, bm_ack = 1'b0;
    logic [31:0] bm_addr, bm_wdata, bm_rdata = '0;
    logic rx_valid, tx_valid, rx_done = 1'b0, tx_done = 1'b0;
    logic [11:0] rx_count, tx_count;
    logic [31:0] rx_buf_addr, tx_buf_addr;
    logic [6:0] rx_flags, tx_flags, rx_done_flags = '0, tx_done_flags = '0;

    always #2 clk = ~clk;

    ring_dma_seq i_ring_dma_seq (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .prompt(prompt),
        .page(PG), .ring_base(BS), .size_wr(size_wr), .size_wdata(size_wdata),
        .size_q(size_q), .ring_ptr(ring_ptr), .bm_req(bm_req), .bm_we(bm_we),
        .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_ack(bm_ack), .bm_rdata(bm_rdata),
        .rx_valid(rx_valid), .rx_count(rx_count), .rx_buf_addr(rx_buf_addr),
        .rx_flags(rx_flags), .rx_done(rx_done), .rx_done_flags(rx_done_flags),
        .tx_valid(tx_valid), .tx_count(tx_count), .tx_buf_addr(tx_buf_addr),
        .tx_flags(tx_flags), .tx_done(tx_done), .tx_done_flags(tx_done_flags)
    );

    // host memory model: one-cycle acknowledge
    logic [31:0] mem [256];
    logic host_wr = 1'b0;
    logic [7:0] host_a = '0;
    logic [31:0] host_d = '0;
    logic bad_addr = 1'b0;

    always @(posedge clk) begin
        if (host_wr) mem[host_a] <= host_d;
        bm_ack <= 1'b0;
        if (bm_req && !bm_ack) begin
            bm_ack   <= 1'b1;
            bm_rdata <= mem[bm_addr[9:2]];
            if (bm_we) mem[bm_addr[9:2]] <= bm_wdata;
            if (bm_addr[31:10] != {PG, BS}) bad_addr <= 1'b1;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] buf_of(input int r, input int i);
        return 24'h100000 + 24'(r) * 24'h1000 + 24'(i) * 24'h20;
    endfunction

    function automatic logic [11:0] cnt_of(input int r, input int i);
        return 12'h100 + 12'(r) * 12'h40 + 12'(i);
    endfunction

    task automatic setup_ring(input int r, input int n);
        for (int i = 0; i < 64; i++) begin
            host_a = 8'((r * 64 + i) * 2); host_d = {20'hA5A5A, cnt_of(r, i)}; host_wr = 1'b1;
            @(negedge clk);
            host_a = 8'((r * 64 + i) * 2 + 1); host_d = {(i < n), 7'h15, buf_of(r, i)};
            @(negedge clk);
        end
        host_wr = 1'b0;
    endtask

    task automatic write_size(input logic [15:0] v);
        size_wdata = v; size_wr = 1'b1; @(negedge clk); size_wr = 1'b0;
    endtask

    task automatic pulse_prompt();
        prompt = 1'b1; @(negedge clk); prompt = 1'b0;
    endtask

    task automatic serve(input int nrx, input int ntx, input int rsz, input int tsz);
        int kr = 0, kt = 0, guard = 0;
        logic [63:0] expv;
        while ((kr < nrx || kt < ntx) && guard < 20000) begin
            @(negedge clk);
            guard++;
            rx_done = 1'b0; tx_done = 1'b0;
            if (rx_valid && kr < nrx) begin
                expv = {13'd0, cnt_of(0, kr % rsz), PG, buf_of(0, kr % rsz), 7'h15};
                chk("R4", "rx descriptor", {13'd0, rx_count, rx_buf_addr, rx_flags}, expv);
                rx_done = 1'b1; rx_done_flags = 7'h2A ^ 7'(kr % rsz); kr++;
            end
            if (tx_valid && kt < ntx) begin
                expv = {13'd0, cnt_of(1, kt % tsz), PG, buf_of(1, kt % tsz), 7'h15};
                chk("R4", "tx descriptor", {13'd0, tx_count, tx_buf_addr, tx_flags}, expv);
                tx_done = 1'b1; tx_done_flags = 7'h2A ^ 7'(kt % tsz); kt++;
            end
        end
        @(negedge clk); rx_done = 1'b0; tx_done = 1'b0;
        chk("R7", "frames served before timeout", 64'(guard < 20000), 64'd1);
    endtask

    // {rx code, tx code, rx frames, tx frames, exp rx idx, exp tx idx}
    localparam logic [33:0] VEC [5] = '{
        {4'b0000, 4'b0000, 7'd2,  7'd3,  6'd2, 6'd3},
        {4'b0001, 4'b0000, 7'd8,  7'd4,  6'd0, 6'd0},
        {4'b0011, 4'b0001, 7'd5,  7'd8,  6'd5, 6'd0},
        {4'b1111, 4'b0111, 7'd64, 7'd20, 6'd0, 6'd20},
        {4'b0111, 4'b1111, 7'd0,  7'd1,  6'd0, 6'd1}
    };

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ptr after reset", 64'(ring_ptr), 64'd0);
        chk("R1", "size after reset", 64'(size_q), 64'd0);
        chk("R1", "idle after reset", {62'd0, bm_req, rx_valid | tx_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 size register field layout
        write_size(16'hF3FF);
        chk("R2", "size readback", 64'(size_q), 64'h0000_F300);
        write_size(16'h0000);

        // R8 / R10: both rings prompted together
        setup_ring(0, 1);
        setup_ring(1, 1);
        master_en = 1'b1; @(negedge clk);
        pulse_prompt();
        chk("R10", "rx wins first grant", {31'd0, bm_req, bm_addr}, {31'd0, 1'b1, PG, BS, 1'b0, 6'd0, 1'b0, 2'b00});
        begin
            int g = 0;
            while (!(bm_req && bm_addr[9]) && g < 50) begin @(negedge clk); g++; end
            chk("R8", "tx first address", 64'(bm_addr), 64'({PG, BS, 1'b1, 6'd0, 1'b0, 2'b00}));
            g = 0;
            while (!(rx_valid && tx_valid) && g < 50) begin @(negedge clk); g++; end
        end
        chk("R4", "both descriptors held", {62'd0, rx_valid, tx_valid}, 64'd3);
        // R3 prompt on busy rings is ignored
        pulse_prompt();
        repeat (4) @(negedge clk);
        chk("R3", "held after prompt", {rx_valid, tx_valid, bm_req, 13'd0, ring_ptr, 4'd0, rx_count, 4'd0, tx_count},
            {1'b1, 1'b1, 1'b0, 13'd0, 16'd0, 4'd0, cnt_of(0, 0), 4'd0, cnt_of(1, 0)});
        // R11 disable clears everything
        master_en = 1'b0; @(negedge clk);
        chk("R11", "disabled rings idle", {rx_valid, tx_valid, bm_req, 45'd0, ring_ptr}, 64'd0);
        master_en = 1'b1; repeat (5) @(negedge clk);
        chk("R11", "re-enable without prompt stays idle", {62'd0, bm_req, rx_valid}, 64'd0);

        // table walk
        foreach (VEC[v]) begin
            int rsz, tsz, nrx, ntx, mis;
            logic [3:0] rc, tc;
            rc = VEC[v][33:30]; tc = VEC[v][29:26];
            nrx = int'(VEC[v][25:19]); ntx = int'(VEC[v][18:12]);
            rsz = int'({rc, 2'b11}) + 1; tsz = int'({tc, 2'b11}) + 1;
            master_en = 1'b0;
            setup_ring(0, nrx);
            setup_ring(1, ntx);
            bad_addr = 1'b0;
            write_size({tc, rc, 8'h00});
            chk("R2", "size code readback", 64'(size_q), 64'({tc, rc, 8'h00}));
            master_en = 1'b1; @(negedge clk);
            pulse_prompt();
            serve(nrx, ntx, rsz, tsz);
            repeat (12) @(negedge clk);
            chk("R9", "pointer readback", 64'(ring_ptr),
                64'({2'b00, VEC[v][5:0], 2'b00, VEC[v][11:6]}));
            chk("R5", "rings idle at unowned entry", {62'd0, bm_req, rx_valid | tx_valid}, 64'd0);
            chk("R8", "all bus addresses in area", 64'(bad_addr), 64'd0);
            mis = 0;
            for (int i = 0; i < nrx; i++)
                if (mem[8'(i * 2 + 1)] !== {1'b0, 7'h2A ^ 7'(i), buf_of(0, i)}) mis++;
            for (int i = 0; i < ntx; i++)
                if (mem[8'((64 + i) * 2 + 1)] !== {1'b0, 7'h2A ^ 7'(i), buf_of(1, i)}) mis++;
            chk("R6", "closed descriptors written back", 64'(mis), 64'd0);
        end

        // R5 directed: nothing owned
        master_en = 1'b0;
        setup_ring(0, 0);
        setup_ring(1, 0);
        master_en = 1'b1; @(negedge clk);
        pulse_prompt();
        repeat (10) @(negedge clk);
        chk("R5", "unowned leaves idle", {rx_valid, tx_valid, bm_req, 45'd0, ring_ptr}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule